// File: doc/BRIEF.md
# Platform System Control Registers

This block is a byte-wide register file that sits on an ISA-style port bus. It answers to a single port at 0x092 and to a window of ports between 0x800 and 0x851. Writes to a handful of these ports set sideband outputs: a soft-reset level, a little-endian mode flag, a disk activity indicator, a small system-control field and an I/O map-type select. Writes to two password ports emit single-clock lock-toggle pulses for an attached non-volatile memory. Those ports keep no data.

Reads return either the live value of a writable field or a fixed identification byte. A read of any port that is not decoded returns all ones. Read data is registered: it appears on the clock after the read strobe and holds until the next read. Writes to read-only or undecoded ports change nothing.

Top module: `plat_sysctl_regs`

## Requirements
- R1: A write to port 0x092 copies data bit 0 to `soft_reset` and data bit 1 to `little_endian`. Both outputs change on the clock edge that samples the write.
- R2: A read of port 0x092 returns the little-endian flag in bit 1 and zero in every other bit.
- R3: A write to port 0x808 copies data bit 0 to `disk_led`.
- R4: A write to port 0x810 makes `lock1_toggle` high for exactly the one cycle after the write edge. A write to 0x812 does the same on `lock2_toggle`. Neither port stores data, so a read of 0x810 still returns its identification byte 0x39.
- R5: A write to port 0x81C stores the low 4 data bits in `sys_ctrl`. A read of 0x81C returns them zero-extended to 8 bits. No other port changes `sys_ctrl`.
- R6: A write to port 0x850 stores data bit 0 in `map_contig`. A read of 0x850 returns that flag in bit 0 with the other bits zero.
- R7: The identification reads are: 0x800 returns 0xEF, 0x802 returns 0xAD, 0x803 returns 0xE0, 0x80C returns 0x3C, 0x810 returns 0x39, 0x818 returns 0x00 and 0x823 returns 0x03.
- R8: A read of any other address returns 0xFF. This includes 0x808, 0x812 and 0x814. A write to an identification port, to 0x814 or to an undecoded address leaves every output unchanged.
- R9: A synchronous reset drives `soft_reset`, `little_endian`, `disk_led`, `sys_ctrl`, `map_contig`, both lock pulses and `io_rdata` to zero.
- R10: `io_rdata` takes the addressed value on the clock edge that samples `io_rd`. It holds that value while no read is strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_addr | input | ADDR_W | Port address |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, one write per cycle it is high |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Registered read data |
| soft_reset | output | 1 | Soft-reset request level |
| little_endian | output | 1 | Little-endian mode flag |
| disk_led | output | 1 | Disk activity indicator |
| sys_ctrl | output | CTRL_W | System-control field |
| map_contig | output | 1 | I/O map-type select |
| lock1_toggle | output | 1 | One-cycle toggle request for memory lock 1 |
| lock2_toggle | output | 1 | One-cycle toggle request for memory lock 2 |

## Verification
On every cycle the assertions check four things. The port 0x092 bits reach their two outputs after each write. The lock pulses last one cycle after their own write only and never overlap. The control field and map flag move only when their own port is written. A read of 0x814 returns all ones. The directed scenarios are needed for the rest: every identification byte, the read-back formats, writes to read-only and undecoded ports leaving all state unchanged, read data holding between reads, and a reset in the middle of operation clearing all state.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

   localparam int DATA_W   = 8;
   localparam int PADDR_W  = 12;
   localparam int NPORT    = 13;

   typedef enum int {
      PI_SPECIAL = 0,
      PI_CPUCFG  = 1,
      PI_FEAT    = 2,
      PI_STAT    = 3,
      PI_DISK    = 4,
      PI_EQUIP   = 5,
      PI_LOCK1   = 6,
      PI_LOCK2   = 7,
      PI_L2INV   = 8,
      PI_KEY     = 9,
      PI_CTRL    = 10,
      PI_L2STAT  = 11,
      PI_MAP     = 12
   } port_idx_e;

   // decoded port address for each index
   function automatic logic [PADDR_W-1:0] port_addr(int idx);
      case (idx)
         PI_SPECIAL: port_addr = 12'h092;
         PI_CPUCFG:  port_addr = 12'h800;
         PI_FEAT:    port_addr = 12'h802;
         PI_STAT:    port_addr = 12'h803;
         PI_DISK:    port_addr = 12'h808;
         PI_EQUIP:   port_addr = 12'h80C;
         PI_LOCK1:   port_addr = 12'h810;
         PI_LOCK2:   port_addr = 12'h812;
         PI_L2INV:   port_addr = 12'h814;
         PI_KEY:     port_addr = 12'h818;
         PI_CTRL:    port_addr = 12'h81C;
         PI_L2STAT:  port_addr = 12'h823;
         default:    port_addr = 12'h850;
      endcase
   endfunction

   // {valid, byte}: fixed identification value returned on a read
   function automatic logic [DATA_W:0] id_byte(int idx);
      case (idx)
         PI_CPUCFG:  id_byte = {1'b1, 8'hEF};
         PI_FEAT:    id_byte = {1'b1, 8'hAD};
         PI_STAT:    id_byte = {1'b1, 8'hE0};
         PI_EQUIP:   id_byte = {1'b1, 8'h3C};
         PI_LOCK1:   id_byte = {1'b1, 8'h39};
         PI_KEY:     id_byte = {1'b1, 8'h00};
         PI_L2STAT:  id_byte = {1'b1, 8'h03};
         default:    id_byte = {1'b0, 8'hFF};
      endcase
   endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
   import sysctl_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [NPORT-1:0]  hit
);

   generate
      if (ADDR_W < PADDR_W) begin : g_bad_width
         $error("sysctl_decode: ADDR_W must be at least %0d", PADDR_W);
      end
   endgenerate

   for (genvar g = 0; g < NPORT; g++) begin : g_cmp
      assign hit[g] = (addr == ADDR_W'(port_addr(g)));
   end

endmodule

// File: rtl/sysctl_state.sv
module sysctl_state
   import sysctl_pkg::*;
#(
   parameter int CTRL_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [NPORT-1:0]  hit,
   output logic              soft_reset,
   output logic              little_endian,
   output logic              disk_led,
   output logic [CTRL_W-1:0] sys_ctrl,
   output logic              map_contig,
   output logic              lock1_toggle,
   output logic              lock2_toggle
);

   generate
      if (CTRL_W < 1 || CTRL_W > DATA_W) begin : g_bad_ctrl
         $error("sysctl_state: CTRL_W must lie in 1..%0d", DATA_W);
      end
   endgenerate

   logic [NPORT-1:0] we;
   assign we = {NPORT{wr}} & hit;

   always_ff @(posedge clk) begin
      if (rst) begin
         soft_reset    <= 1'b0;
         little_endian <= 1'b0;
         disk_led      <= 1'b0;
         sys_ctrl      <= '0;
         map_contig    <= 1'b0;
      end else begin
         if (we[PI_SPECIAL]) begin
            soft_reset    <= wdata[0];
            little_endian <= wdata[1];
         end
         if (we[PI_DISK]) disk_led   <= wdata[0];
         if (we[PI_CTRL]) sys_ctrl   <= wdata[CTRL_W-1:0];
         if (we[PI_MAP])  map_contig <= wdata[0];
      end
   end

   // lock requests: one registered pulse per write cycle
   always_ff @(posedge clk) begin
      if (rst) begin
         lock1_toggle <= 1'b0;
         lock2_toggle <= 1'b0;
      end else begin
         lock1_toggle <= we[PI_LOCK1];
         lock2_toggle <= we[PI_LOCK2];
      end
   end

endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
   import sysctl_pkg::*;
#(
   parameter int CTRL_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rd,
   input  logic [NPORT-1:0]  hit,
   input  logic              little_endian,
   input  logic [CTRL_W-1:0] sys_ctrl,
   input  logic              map_contig,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] ctrl_ext;
   logic [DATA_W-1:0] id_val;
   logic [DATA_W-1:0] rd_next;

   generate
      if (CTRL_W == DATA_W) begin : g_ctrl_full
         assign ctrl_ext = sys_ctrl;
      end else begin : g_ctrl_pad
         assign ctrl_ext = {{(DATA_W-CTRL_W){1'b0}}, sys_ctrl};
      end
   endgenerate

   always_comb begin
      id_val = '1;
      for (int i = 0; i < NPORT; i++) begin
         if (hit[i] && id_byte(i)[DATA_W]) id_val = id_byte(i)[DATA_W-1:0];
      end
   end

   always_comb begin
      if (hit[PI_SPECIAL])   rd_next = {{(DATA_W-2){1'b0}}, little_endian, 1'b0};
      else if (hit[PI_CTRL]) rd_next = ctrl_ext;
      else if (hit[PI_MAP])  rd_next = {{(DATA_W-1){1'b0}}, map_contig};
      else                   rd_next = id_val;
   end

   always_ff @(posedge clk) begin
      if (rst)     rdata <= '0;
      else if (rd) rdata <= rd_next;
   end

endmodule

// File: rtl/plat_sysctl_regs.sv
module plat_sysctl_regs
   import sysctl_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int CTRL_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [7:0]        io_wdata,
   input  logic              io_wr,
   input  logic              io_rd,
   output logic [7:0]        io_rdata,
   output logic              soft_reset,
   output logic              little_endian,
   output logic              disk_led,
   output logic [CTRL_W-1:0] sys_ctrl,
   output logic              map_contig,
   output logic              lock1_toggle,
   output logic              lock2_toggle
);

   logic [NPORT-1:0] hit;

   sysctl_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr (io_addr),
      .hit  (hit)
   );

   sysctl_state #(.CTRL_W(CTRL_W)) u_state (
      .clk           (clk),
      .rst           (rst),
      .wr            (io_wr),
      .wdata         (io_wdata),
      .hit           (hit),
      .soft_reset    (soft_reset),
      .little_endian (little_endian),
      .disk_led      (disk_led),
      .sys_ctrl      (sys_ctrl),
      .map_contig    (map_contig),
      .lock1_toggle  (lock1_toggle),
      .lock2_toggle  (lock2_toggle)
   );

   sysctl_rdmux #(.CTRL_W(CTRL_W)) u_rd (
      .clk           (clk),
      .rst           (rst),
      .rd            (io_rd),
      .hit           (hit),
      .little_endian (little_endian),
      .sys_ctrl      (sys_ctrl),
      .map_contig    (map_contig),
      .rdata         (io_rdata)
   );

endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk #(
   parameter int ADDR_W = 12,
   parameter int CTRL_W = 4
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] io_addr,
   input logic [7:0]        io_wdata,
   input logic              io_wr,
   input logic              io_rd,
   input logic [7:0]        io_rdata,
   input logic              soft_reset,
   input logic              little_endian,
   input logic [CTRL_W-1:0] sys_ctrl,
   input logic              map_contig,
   input logic              lock1_toggle,
   input logic              lock2_toggle
);

   logic wr92, wr810, wr812, wr81c, wr850, rd814;
   assign wr92  = io_wr && (io_addr == ADDR_W'(12'h092));
   assign wr810 = io_wr && (io_addr == ADDR_W'(12'h810));
   assign wr812 = io_wr && (io_addr == ADDR_W'(12'h812));
   assign wr81c = io_wr && (io_addr == ADDR_W'(12'h81C));
   assign wr850 = io_wr && (io_addr == ADDR_W'(12'h850));
   assign rd814 = io_rd && (io_addr == ADDR_W'(12'h814));

   AST_SPECIAL_PORT: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(wr92)) |->
         (soft_reset == $past(io_wdata[0]) && little_endian == $past(io_wdata[1]))); // R1

   AST_LOCK1_PULSE: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (lock1_toggle == $past(wr810))); // R4

   AST_LOCK2_PULSE: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (lock2_toggle == $past(wr812))); // R4

   AST_LOCK_EXCL: assert property (@(posedge clk) disable iff (rst)
      !(lock1_toggle && lock2_toggle)); // R4

   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(wr81c)) |-> $stable(sys_ctrl)); // R5

   AST_MAP_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(wr850)) |-> $stable(map_contig)); // R6

   AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(rd814)) |-> (io_rdata == 8'hFF)); // R8

endmodule

bind plat_sysctl_regs sysctl_regs_chk #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) u_chk (
   .clk           (clk),
   .rst           (rst),
   .io_addr       (io_addr),
   .io_wdata      (io_wdata),
   .io_wr         (io_wr),
   .io_rd         (io_rd),
   .io_rdata      (io_rdata),
   .soft_reset    (soft_reset),
   .little_endian (little_endian),
   .sys_ctrl      (sys_ctrl),
   .map_contig    (map_contig),
   .lock1_toggle  (lock1_toggle),
   .lock2_toggle  (lock2_toggle)
);

// File: tb/tb_plat_sysctl_regs.sv
module tb_plat_sysctl_regs;

   localparam int AW = 12;
   localparam int CW = 4;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [AW-1:0] io_addr = '0;
   logic [7:0]    io_wdata = '0;
   logic          io_wr = 1'b0;
   logic          io_rd = 1'b0;
   logic [7:0]    io_rdata;
   logic          soft_reset, little_endian, disk_led, map_contig;
   logic [CW-1:0] sys_ctrl;
   logic          lock1_toggle, lock2_toggle;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   plat_sysctl_regs #(.ADDR_W(AW), .CTRL_W(CW)) dut (
      .clk(clk), .rst(rst), .io_addr(io_addr), .io_wdata(io_wdata),
      .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
      .soft_reset(soft_reset), .little_endian(little_endian),
      .disk_led(disk_led), .sys_ctrl(sys_ctrl), .map_contig(map_contig),
      .lock1_toggle(lock1_toggle), .lock2_toggle(lock2_toggle)
   );

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
      end
   endtask

   // returns at the falling edge after the sampling edge
   task automatic wr_port(input logic [AW-1:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic rd_port(input logic [AW-1:0] a, output logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      @(negedge clk);
      io_rd = 1'b0;
      d = io_rdata;
   endtask

   function automatic logic [7:0] outs();
      return {1'b0, soft_reset, little_endian, disk_led, map_contig, 3'b000};
   endfunction

   task automatic t_reset_state();
      check("R9 reset outputs", outs(), 8'h00);
      check("R9 reset ctrl", 8'(sys_ctrl), 8'h00);
      check("R9 reset locks", {6'b0, lock1_toggle, lock2_toggle}, 8'h00);
      check("R9 reset rdata", io_rdata, 8'h00);
   endtask

   task automatic t_special();
      logic [7:0] r;
      wr_port(12'h092, 8'h03);
      check("R1 write 03", {6'b0, soft_reset, little_endian}, 8'h03);
      rd_port(12'h092, r);
      check("R2 read le=1", r, 8'h02);
      wr_port(12'h092, 8'h02);
      check("R1 write 02", {6'b0, soft_reset, little_endian}, 8'h01);
      wr_port(12'h092, 8'h01);
      check("R1 write 01", {6'b0, soft_reset, little_endian}, 8'h02);
      rd_port(12'h092, r);
      check("R2 read le=0", r, 8'h00);
      wr_port(12'h092, 8'hFC);
      check("R1 write FC", {6'b0, soft_reset, little_endian}, 8'h00);
   endtask

   task automatic t_disk();
      wr_port(12'h808, 8'hFF);
      check("R3 led on", {7'b0, disk_led}, 8'h01);
      wr_port(12'h808, 8'hFE);
      check("R3 led off", {7'b0, disk_led}, 8'h00);
   endtask

   task automatic t_lock();
      logic [7:0] r;
      wr_port(12'h810, 8'h55);
      check("R4 lock1 pulse", {6'b0, lock1_toggle, lock2_toggle}, 8'h02);
      @(negedge clk);
      check("R4 lock1 one cycle", {6'b0, lock1_toggle, lock2_toggle}, 8'h00);
      wr_port(12'h812, 8'h00);
      check("R4 lock2 pulse", {6'b0, lock1_toggle, lock2_toggle}, 8'h01);
      @(negedge clk);
      check("R4 lock2 one cycle", {6'b0, lock1_toggle, lock2_toggle}, 8'h00);
      rd_port(12'h810, r);
      check("R4 no data stored", r, 8'h39);
   endtask

   task automatic t_ctrl_map();
      logic [7:0] r;
      wr_port(12'h81C, 8'hA5);
      check("R5 ctrl low nibble", 8'(sys_ctrl), 8'h05);
      rd_port(12'h81C, r);
      check("R5 ctrl readback", r, 8'h05);
      wr_port(12'h81C, 8'hFA);
      rd_port(12'h81C, r);
      check("R5 ctrl readback 2", r, 8'h0A);
      wr_port(12'h850, 8'hFF);
      check("R6 map set", {7'b0, map_contig}, 8'h01);
      rd_port(12'h850, r);
      check("R6 map readback", r, 8'h01);
      wr_port(12'h850, 8'h0E);
      rd_port(12'h850, r);
      check("R6 map clear", r, 8'h00);
      wr_port(12'h850, 8'h01);
   endtask

   task automatic t_ids();
      logic [7:0] r;
      logic [AW-1:0] a [7] = '{12'h800, 12'h802, 12'h803, 12'h80C, 12'h810, 12'h818, 12'h823};
      logic [7:0]    v [7] = '{8'hEF, 8'hAD, 8'hE0, 8'h3C, 8'h39, 8'h00, 8'h03};
      for (int i = 0; i < 7; i++) begin
         rd_port(a[i], r);
         check($sformatf("R7 id 0x%03h", a[i]), r, v[i]);
      end
   endtask

   task automatic t_unmapped();
      logic [7:0] r;
      logic [AW-1:0] a [7] = '{12'h814, 12'h808, 12'h812, 12'h801, 12'h851, 12'h093, 12'h000};
      for (int i = 0; i < 7; i++) begin
         rd_port(a[i], r);
         check($sformatf("R8 unmapped 0x%03h", a[i]), r, 8'hFF);
      end
   endtask

   task automatic t_ignored();
      logic [7:0] r;
      // known state: le=1, led=1, ctrl=A, map=1
      wr_port(12'h092, 8'h02);
      wr_port(12'h808, 8'h01);
      wr_port(12'h81C, 8'h0A);
      wr_port(12'h850, 8'h01);
      begin
         logic [AW-1:0] a [6] = '{12'h800, 12'h803, 12'h814, 12'h818, 12'h7FF, 12'h851};
         for (int i = 0; i < 6; i++) wr_port(a[i], 8'h00);
      end
      check("R8 ignored writes outs", outs(), 8'h38);
      check("R8 ignored writes ctrl", 8'(sys_ctrl), 8'h0A);
      rd_port(12'h800, r);
      check("R8 id after write", r, 8'hEF);
   endtask

   task automatic t_hold();
      logic [7:0] r;
      rd_port(12'h802, r);
      repeat (3) @(negedge clk);
      check("R10 rdata holds", io_rdata, 8'hAD);
      wr_port(12'h81C, 8'h03);
      check("R10 write leaves rdata", io_rdata, 8'hAD);
   endtask

   task automatic t_midreset();
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      check("R9 mid reset outs", outs(), 8'h00);
      check("R9 mid reset ctrl", 8'(sys_ctrl), 8'h00);
      check("R9 mid reset rdata", io_rdata, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset_state();
      t_special();
      t_disk();
      t_lock();
      t_ctrl_map();
      t_ids();
      t_unmapped();
      t_ignored();
      t_hold();
      t_midreset();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule